// File: doc/BRIEF.md
# Carry-Save Booth Multiply-Accumulate Unit

This block multiplies two signed operands per accepted cycle and adds the product into a running total. The multiplier operand is recoded in radix-4 Booth digits. Negative digits invert the selected multiple and inject the missing +1 as a correction bit. Sign extension is handled by one folded constant row, so no partial product is widened with copied sign bits. All partial-product rows, the correction bits, the sign constant and the previous total enter one carry-save compressor network.

The running total is stored redundantly as a sum vector and a carry vector. The carry-propagate adder therefore never sits in the feedback loop. A few low result bits are resolved inside the accumulation stage with a short adder. Its carry out is held and fed back, so the output adder only spans the upper bits.

A clear flag that arrives with an operand pair starts a new accumulation from that product. The pipeline has three register stages: recoding, accumulation and final addition. Each accepted operand pair produces one valid result carrying the total up to and including that pair.

Top module: `mac_cs_booth`

## Requirements
- R1: For every cycle with `in_valid` high and `clear` low, the total becomes the previous total plus the signed product `op_a * op_b`. Both operands are 16-bit two's complement.
- R2: For a cycle with `in_valid` and `clear` both high, the total becomes exactly `op_a * op_b`, discarding all earlier products.
- R3: `clear` while `in_valid` is low is ignored. The next accepted product adds onto the unchanged total.
- R4: `out_valid` is high in the third cycle after a cycle with `in_valid` high, and only then. Exactly one pulse appears per accepted operand pair.
- R5: While `out_valid` is low, `acc_out` keeps the last presented value.
- R6: During and after reset, `out_valid` is 0 and `acc_out` is 0. The first product accepted after reset without `clear` adds onto a total of zero.
- R7: Extreme operands give exact products: -32768 × -32768 = 2^30, -32768 × 32767, 32767 × 32767, -1 × -1 and -32768 × 1.
- R8: The total is 40 bits wide and wraps modulo 2^40 on overflow, with no saturation. `acc_out` shows it as the 40-bit two's complement pattern.
- R9: Cycles with `in_valid` low leave the accumulation state unchanged, whatever the operands show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is accepted this cycle |
| clear | input | 1 | With `in_valid`, start a new total from this product |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier (Booth-recoded), two's complement |
| out_valid | output | 1 | `acc_out` holds a fresh total |
| acc_out | output | 40 | Resolved running total, two's complement |

## Verification
The hardest case to reach from the ports is overflow of the 40-bit redundant total. In that case the carries out of the sum and carry vectors, and the held early low-bit carry, must all wrap consistently. Reaching it takes more than 512 maximum-magnitude products in a row, so the stimulus clears once and then feeds 1100 consecutive -32768 × -32768 pairs, crossing 2^39 and 2^40. Random bursts with gaps and sparse clears cover the held-carry feedback when the accumulation pauses and resumes.

// File: rtl/mac_cs_pkg.sv
`timescale 1ns/1ps
package mac_cs_pkg;

   // Radix-4 digit selection: magnitude one, magnitude two, negative
   typedef struct packed {
      logic neg;
      logic x1;
      logic x2;
   } booth_sel_t;

   function automatic booth_sel_t booth_decode(input logic [2:0] trip);
      booth_sel_t r;
      r = '0;
      case (trip)
         3'b001, 3'b010: r.x1 = 1'b1;
         3'b011:         r.x2 = 1'b1;
         3'b100:         begin r.x2 = 1'b1; r.neg = 1'b1; end
         3'b101, 3'b110: begin r.x1 = 1'b1; r.neg = 1'b1; end
         default:        r = '0;
      endcase
      return r;
   endfunction

   // Folded sign constant: minus the sum of each row's top-bit weight
   function automatic logic [127:0] sign_fold(input int op_w, input int npp);
      logic [127:0] s;
      s = '0;
      for (int i = 0; i < npp; i++)
         s = s + (128'd1 << (2 * i + op_w + 1));
      return ~s + 128'd1;
   endfunction

endpackage

// File: rtl/mac_booth_rows.sv
`timescale 1ns/1ps
module mac_booth_rows
   import mac_cs_pkg::*;
#(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40,
   localparam int NPP  = OP_W / 2,
   localparam int PP_W = OP_W + 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       clear,
   input  logic [OP_W-1:0]            op_a,
   input  logic [OP_W-1:0]            op_b,
   output logic                       vld_q,
   output logic                       clr_q,
   output logic [NPP-1:0][ACC_W-1:0]  rows_q,
   output logic [ACC_W-1:0]           corr_q
);

   logic [PP_W-1:0]            a_ext;
   logic [OP_W:0]              b_ext;
   logic [NPP-1:0][ACC_W-1:0]  rows_d;
   logic [ACC_W-1:0]           corr_d;

   assign a_ext = {{2{op_a[OP_W-1]}}, op_a};
   assign b_ext = {op_b, 1'b0};

   always_comb begin
      booth_sel_t      sel;
      logic [PP_W-1:0] mag;
      logic [PP_W-1:0] pp;
      rows_d = '0;
      corr_d = '0;
      for (int i = 0; i < NPP; i++) begin
         sel = booth_decode(b_ext[2*i +: 3]);
         if (sel.x1)      mag = a_ext;
         else if (sel.x2) mag = {a_ext[PP_W-2:0], 1'b0};
         else             mag = '0;
         pp = sel.neg ? ~mag : mag;
         // top bit flipped; the removed weight lives in the sign constant
         rows_d[i] = ACC_W'({~pp[PP_W-1], pp[PP_W-2:0]}) << (2 * i);
         corr_d[2*i] = sel.neg;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         clr_q  <= 1'b0;
         rows_q <= '0;
         corr_q <= '0;
      end else begin
         vld_q <= in_valid;
         clr_q <= in_valid & clear;
         if (in_valid) begin
            rows_q <= rows_d;
            corr_q <= corr_d;
         end
      end
   end

endmodule

// File: rtl/mac_csa_accum.sv
`timescale 1ns/1ps
module mac_csa_accum
   import mac_cs_pkg::*;
#(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int EARLY_W = 3,
   localparam int NPP    = OP_W / 2,
   localparam int NV     = NPP + 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       vld_i,
   input  logic                       clr_i,
   input  logic [NPP-1:0][ACC_W-1:0]  rows_i,
   input  logic [ACC_W-1:0]           corr_i,
   output logic                       vld_q,
   output logic [ACC_W-1:0]           sum_q,
   output logic [ACC_W-1:0]           carry_q,
   output logic                       cin_q
);

   localparam logic [ACC_W-1:0] SIGN_K = ACC_W'(sign_fold(OP_W, NPP));

   logic [ACC_W-1:0] fb_sum, fb_carry, corr_all;
   logic             fb_cin;
   logic [ACC_W-1:0] vin [NV];
   logic [ACC_W-1:0] red_s, red_c;
   logic [ACC_W-1:0] sum_d, carry_d;
   logic             cin_d;

   assign fb_sum   = clr_i ? '0 : sum_q;
   assign fb_carry = clr_i ? '0 : carry_q;
   assign fb_cin   = clr_i ? 1'b0 : cin_q;

   // correction row: Booth +1 bits at even positions, held low carry at EARLY_W
   generate
      if (EARLY_W > 0) begin : g_corr_cin
         assign corr_all = corr_i | (ACC_W'(fb_cin) << EARLY_W);
      end else begin : g_corr_plain
         logic unused_cin;
         assign unused_cin = fb_cin;
         assign corr_all   = corr_i;
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NPP; i++) vin[i] = rows_i[i];
      vin[NPP]   = corr_all;
      vin[NPP+1] = SIGN_K;
      vin[NPP+2] = fb_sum;
      vin[NPP+3] = fb_carry;
   end

   // 3:2 compressor chain over all inputs, accumulator included
   always_comb begin
      logic [ACC_W-1:0] t;
      red_s = vin[0];
      red_c = vin[1];
      for (int k = 2; k < NV; k++) begin
         t     = red_s ^ red_c ^ vin[k];
         red_c = ((red_s & red_c) | (red_s & vin[k]) | (red_c & vin[k])) << 1;
         red_s = t;
      end
   end

   generate
      if (EARLY_W > 0) begin : g_early
         logic [EARLY_W:0] lo;
         assign lo      = {1'b0, red_s[EARLY_W-1:0]} + {1'b0, red_c[EARLY_W-1:0]};
         assign sum_d   = {red_s[ACC_W-1:EARLY_W], lo[EARLY_W-1:0]};
         assign carry_d = {red_c[ACC_W-1:EARLY_W], {EARLY_W{1'b0}}};
         assign cin_d   = lo[EARLY_W];
      end else begin : g_late
         assign sum_d   = red_s;
         assign carry_d = red_c;
         assign cin_d   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         sum_q   <= '0;
         carry_q <= '0;
         cin_q   <= 1'b0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) begin
            sum_q   <= sum_d;
            carry_q <= carry_d;
            cin_q   <= cin_d;
         end
      end
   end

endmodule

// File: rtl/mac_final_add.sv
`timescale 1ns/1ps
module mac_final_add #(
   parameter int ACC_W   = 40,
   parameter int EARLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [ACC_W-1:0] sum_i,
   input  logic [ACC_W-1:0] carry_i,
   input  logic             cin_i,
   output logic             vld_q,
   output logic [ACC_W-1:0] res_q
);

   logic [ACC_W-1:0] res_d;

   generate
      if (EARLY_W > 0) begin : g_narrow
         localparam int HI_W = ACC_W - EARLY_W;
         logic [HI_W-1:0] hi;
         logic [EARLY_W-1:0] unused_clo;
         assign unused_clo = carry_i[EARLY_W-1:0];
         assign hi    = sum_i[ACC_W-1:EARLY_W] + carry_i[ACC_W-1:EARLY_W] + HI_W'(cin_i);
         assign res_d = {hi, sum_i[EARLY_W-1:0]};
      end else begin : g_full
         logic unused_cin;
         assign unused_cin = cin_i;
         assign res_d = sum_i + carry_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) res_q <= res_d;
      end
   end

endmodule

// File: rtl/mac_cs_booth.sv
`timescale 1ns/1ps
module mac_cs_booth #(
   parameter int OP_W    = 16,
   parameter int ACC_W   = 40,
   parameter int EARLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             clear,
   input  logic [OP_W-1:0]  op_a,
   input  logic [OP_W-1:0]  op_b,
   output logic             out_valid,
   output logic [ACC_W-1:0] acc_out
);

   localparam int NPP = OP_W / 2;

   generate
      if (OP_W < 4 || (OP_W % 2) != 0) begin : g_bad_op
         $error("OP_W must be even and at least 4");
      end
      if (ACC_W < 2 * OP_W) begin : g_bad_acc
         $error("ACC_W must hold a full product");
      end
      if (EARLY_W < 0 || EARLY_W >= ACC_W) begin : g_bad_early
         $error("EARLY_W out of range");
      end
      if (EARLY_W > 0 && (EARLY_W % 2) == 0 && EARLY_W < 2 * NPP) begin : g_bad_slot
         $error("EARLY_W collides with a Booth correction bit");
      end
   endgenerate

   logic                      s1_vld, s1_clr;
   logic [NPP-1:0][ACC_W-1:0] s1_rows;
   logic [ACC_W-1:0]          s1_corr;
   logic                      acc_vld;
   logic [ACC_W-1:0]          acc_sum, acc_carry;
   logic                      acc_cin;

   mac_booth_rows #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
      .op_a(op_a), .op_b(op_b),
      .vld_q(s1_vld), .clr_q(s1_clr), .rows_q(s1_rows), .corr_q(s1_corr)
   );

   mac_csa_accum #(.OP_W(OP_W), .ACC_W(ACC_W), .EARLY_W(EARLY_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .vld_i(s1_vld), .clr_i(s1_clr),
      .rows_i(s1_rows), .corr_i(s1_corr),
      .vld_q(acc_vld), .sum_q(acc_sum), .carry_q(acc_carry), .cin_q(acc_cin)
   );

   mac_final_add #(.ACC_W(ACC_W), .EARLY_W(EARLY_W)) u_fin (
      .clk(clk), .rst_n(rst_n), .vld_i(acc_vld),
      .sum_i(acc_sum), .carry_i(acc_carry), .cin_i(acc_cin),
      .vld_q(out_valid), .res_q(acc_out)
   );

endmodule

// File: rtl/mac_cs_booth_chk.sv
`timescale 1ns/1ps
module mac_cs_booth_chk #(
   parameter int OP_W  = 16,
   parameter int ACC_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             clear,
   input logic [OP_W-1:0]  op_b,
   input logic             out_valid,
   input logic [ACC_W-1:0] acc_out,
   input logic             s1_vld,
   input logic [ACC_W-1:0] acc_sum,
   input logic [ACC_W-1:0] acc_carry
);

   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R4
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(acc_out));

   // R9
   acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_vld |=> ($stable(acc_sum) && $stable(acc_carry)));

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst == 2'd3) && $past(in_valid && clear && (op_b == '0), 3))
         |-> (out_valid && (acc_out == '0)));

endmodule

bind mac_cs_booth mac_cs_booth_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
   .op_b(op_b), .out_valid(out_valid), .acc_out(acc_out),
   .s1_vld(s1_vld), .acc_sum(acc_sum), .acc_carry(acc_carry)
);

// File: tb/tb_mac_cs_booth.sv
`timescale 1ns/1ps
module tb_mac_cs_booth;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic               clear = 1'b0;
   logic signed [15:0] op_a = '0;
   logic signed [15:0] op_b = '0;
   logic               out_valid;
   logic [39:0]        acc_out;

   mac_cs_booth dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear(clear),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .acc_out(acc_out)
   );

   always #2.5 clk = ~clk;

   // behavioural model: running total plus a three-deep delay line
   logic [39:0] acc_m = '0;
   logic        pv [3] = '{1'b0, 1'b0, 1'b0};
   logic [39:0] pr [3] = '{40'd0, 40'd0, 40'd0};
   logic [39:0] last_res = '0;
   int          n_vec = 0;
   int          n_bad = 0;
   string       req = "R6";
   bit          done = 1'b0;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic check_out();
      n_vec++;
      // R4: valid timing
      if (out_valid !== pv[2]) begin
         n_bad++;
         $display("FAIL R4: out_valid=%0b expected %0b", out_valid, pv[2]);
      end
      if (pv[2]) begin
         last_res = pr[2];
         if (acc_out !== pr[2]) begin
            n_bad++;
            $display("FAIL %s: acc_out=%h expected %h", req, acc_out, pr[2]);
         end
      end else if (acc_out !== last_res) begin
         n_bad++;
         $display("FAIL R5: acc_out=%h expected held %h", acc_out, last_res);
      end
   endtask

   task automatic cyc(input logic v, input logic c,
                      input logic signed [15:0] x, input logic signed [15:0] y);
      @(negedge clk);
      check_out();
      pv[2] = pv[1]; pr[2] = pr[1];
      pv[1] = pv[0]; pr[1] = pr[0];
      in_valid = v; clear = c; op_a = x; op_b = y;
      if (v) acc_m = (c ? 40'd0 : acc_m) + 40'(longint'(x) * longint'(y));
      pv[0] = v; pr[0] = acc_m;
   endtask

   initial begin
      // R6: reset state
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         n_vec++;
         if (out_valid !== 1'b0 || acc_out !== 40'd0) begin
            n_bad++;
            $display("FAIL R6: out_valid=%0b acc_out=%h expected 0 0", out_valid, acc_out);
         end
      end
      rst_n = 1'b1;

      // R6: first product starts from zero without clear
      req = "R6";
      cyc(1, 0, 3, -7);
      // R1 and R9: small products with gaps carrying junk operands
      req = "R1";
      cyc(1, 0, 100, 200);
      cyc(0, 0, 12345, -999);
      cyc(1, 0, -5, 9);
      cyc(0, 0, -32768, -32768);
      cyc(0, 0, 777, 777);
      req = "R9";
      cyc(1, 0, 1, 1);
      // R7: extreme operands, each starting a fresh total
      req = "R7";
      cyc(1, 1, -32768, -32768);
      cyc(1, 1, -32768, 32767);
      cyc(1, 1, 32767, 32767);
      cyc(1, 1, -1, -1);
      cyc(1, 1, -32768, 1);
      cyc(1, 0, 32767, -32768);
      // R3: clear without valid is ignored
      req = "R3";
      cyc(0, 1, 0, 0);
      cyc(1, 0, 2, 2);
      // R2: clear with valid restarts, including a zero product
      req = "R2";
      cyc(1, 1, 5, 6);
      cyc(1, 0, 7, 8);
      cyc(1, 1, 1234, 0);
      cyc(1, 0, -3, 3);
      // R1: random traffic with gaps and sparse clears
      req = "R1";
      for (int i = 0; i < 400; i++)
         cyc(($urandom % 4) != 0, ($urandom % 20) == 0,
             16'($urandom), 16'($urandom));
      // R8: long run past the 40-bit range
      req = "R8";
      cyc(1, 1, -32768, -32768);
      for (int i = 0; i < 1100; i++) cyc(1, 0, -32768, -32768);
      for (int i = 0; i < 50; i++) cyc(1, 0, 32767, -32768);
      req = "R1";
      for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

endmodule